// File: doc/BRIEF.md
# Unaligned Left-Partial Lane Merger

This block does the byte-lane arithmetic behind left-hand partial loads and stores against a 64-bit memory doubleword. A request carries the low three virtual-address bits, the low three physical-address bits, three endianness controls (CPU byte order, a reversal of the running order, and memory byte order), an access size (4-byte word or 8-byte doubleword), the 64-bit doubleword read from memory and the current 64-bit register value. From these it forms a byte offset and a word-half select. It then derives two bit counts, one taken from memory and one kept from the register. These counts set the shift amounts and the merge mask.

Each response carries both results, so the same request serves a load or a store. For a load it gives the merged register value. For a store it gives the shifted store data, a byte-lane enable, the byte offset and the adjusted low physical address bits. Requests enter on a valid/ready port and results leave on a valid/ready port through a one-entry output register. A request is taken on any edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in that cycle. A response stays on the port, unchanged, until `rsp_ready` is seen high.

Top module: `lsl_merge_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at an edge appears with `rsp_valid` high after that edge. While `rsp_valid` is high and `rsp_ready` is low, every response field holds and `req_ready` is low. With `rsp_ready` held high, a single request gives a `rsp_valid` pulse of exactly one cycle.
- R3: Let A be 3 for a word and 7 for a doubleword. Let X be `req_vaddr_lo`, inverted in all three bits when `req_cpu_big` is 1. Then `rsp_offset` = X mod (A+1). The half select H is bit 2 of X for a word and 0 for a doubleword.
- R4: Load with H=0: register lanes A−offset through A take memory lanes 0 through offset, in order. Lane n is bits 8n+7..8n.
- R5: Load with H=1 (word only): register lanes 3−offset through 3 take memory lanes 4 through 4+offset, in order.
- R6: On a load, every register lane outside the replaced range passes through unchanged. This includes lanes 4..7 on any word access.
- R7: Store with H=0: store lane i holds register lane i+A−offset where that index is at most 7, and 0 elsewhere.
- R8: Store with H=1: store lane i holds register lane i−offset−1 where that index is at least 0, and 0 elsewhere.
- R9: `rsp_byte_en` has bits 4H through 4H+offset set and all other bits clear.
- R10: `rsp_paddr_lo` is `req_paddr_lo`, inverted in all three bits when `req_rev_endian` is 1. When `req_mem_big` is 0, the bits that are set in A are then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr_lo | input | 3 | Low virtual-address bits |
| req_paddr_lo | input | 3 | Low physical-address bits |
| req_cpu_big | input | 1 | CPU runs big-endian |
| req_rev_endian | input | 1 | Reverse running byte order |
| req_mem_big | input | 1 | Memory is big-endian |
| req_dword | input | 1 | 1: doubleword access, 0: word access |
| req_mem_data | input | 64 | Doubleword read from memory |
| req_reg_data | input | 64 | Current register value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_load_data | output | 64 | Merged register value for a load |
| rsp_store_data | output | 64 | Shifted data for a store |
| rsp_byte_en | output | 8 | Store byte-lane enable |
| rsp_offset | output | 3 | Byte offset inside the access |
| rsp_paddr_lo | output | 3 | Adjusted low physical-address bits |

## Verification
The assertions check the handshake on every cycle: an accepted request always leads to a response, a stalled response holds its fields and blocks new requests, and the byte enable always starts at lane 0 or lane 4 with a population of offset+1. The lane arithmetic is shown only by the bench. It compares the load merge, the store shift, the offset and the address adjustment with a lane-by-lane reference model, over every address offset, both CPU byte orders, both access sizes, both memory orders and a long random run.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  localparam int DATA_W  = 64;
  localparam int LANES   = DATA_W / 8;
  localparam int ADDR_W  = $clog2(LANES);
  localparam int CNT_W   = $clog2(DATA_W) + 1;
  localparam int LANE_IW = ADDR_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] acc;
    logic [ADDR_W-1:0] offset;
    logic              half;
    logic [CNT_W-1:0]  taken;
    logic [CNT_W-1:0]  kept;
  } lane_geom_t;
endpackage

// File: rtl/lsl_lane_calc.sv
module lsl_lane_calc
  import lsl_pkg::*;
(
  input  logic [ADDR_W-1:0] vaddr_lo,
  input  logic              cpu_big,
  input  logic              dword,
  output lane_geom_t        geom
);
  logic [ADDR_W-1:0] acc;
  logic [ADDR_W-1:0] xa;
  logic [ADDR_W-1:0] hsel;

  always_comb begin
    acc  = dword ? ADDR_W'(LANES - 1) : ADDR_W'(LANES / 2 - 1);
    xa   = vaddr_lo ^ {ADDR_W{cpu_big}};
    hsel = xa & ~acc;
    geom.acc    = acc;
    geom.offset = xa & acc;
    geom.half   = |hsel;
    geom.taken  = {1'b0, geom.offset, 3'b000} + CNT_W'(8);
    geom.kept   = {1'b0, acc, 3'b000} - {1'b0, geom.offset, 3'b000};
  end
endmodule

// File: rtl/lsl_load_merge.sv
module lsl_load_merge
  import lsl_pkg::*;
(
  input  lane_geom_t        geom,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] reg_data,
  output logic [DATA_W-1:0] load_data
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;
  logic [CNT_W:0]    span;

  assign span    = {1'b0, geom.kept} + {1'b0, geom.taken};
  assign shifted = geom.half ? (mem_data >> geom.taken) : (mem_data << geom.kept);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = ({1'b0, CNT_W'(i)} >= {1'b0, geom.kept}) &&
                     ({1'b0, CNT_W'(i)} <  span);
  end

  assign load_data = (reg_data & ~mask) | (shifted & mask);
endmodule

// File: rtl/lsl_store_shift.sv
module lsl_store_shift
  import lsl_pkg::*;
(
  input  lane_geom_t        geom,
  input  logic [DATA_W-1:0] reg_data,
  output logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  byte_en
);
  logic [LANE_IW-1:0] base;
  logic [LANE_IW-1:0] last;

  assign store_data = geom.half ? (reg_data << geom.taken) : (reg_data >> geom.kept);
  assign base       = geom.half ? LANE_IW'(LANES / 2) : '0;
  assign last       = base + {1'b0, geom.offset};

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign byte_en[l] = (LANE_IW'(l) >= base) && (LANE_IW'(l) <= last);
  end
endmodule

// File: rtl/lsl_paddr_adj.sv
module lsl_paddr_adj
  import lsl_pkg::*;
(
  input  logic [ADDR_W-1:0] paddr_lo,
  input  logic              rev_endian,
  input  logic              mem_big,
  input  logic [ADDR_W-1:0] acc,
  output logic [ADDR_W-1:0] paddr_out
);
  logic [ADDR_W-1:0] flipped;
  assign flipped   = paddr_lo ^ {ADDR_W{rev_endian}};
  assign paddr_out = mem_big ? flipped : (flipped & ~acc);
endmodule

// File: rtl/lsl_merge_top.sv
module lsl_merge_top
  import lsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_vaddr_lo,
  input  logic [2:0]        req_paddr_lo,
  input  logic              req_cpu_big,
  input  logic              req_rev_endian,
  input  logic              req_mem_big,
  input  logic              req_dword,
  input  logic [63:0]       req_mem_data,
  input  logic [63:0]       req_reg_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_load_data,
  output logic [63:0]       rsp_store_data,
  output logic [7:0]        rsp_byte_en,
  output logic [2:0]        rsp_offset,
  output logic [2:0]        rsp_paddr_lo
);
  lane_geom_t        geom;
  logic [DATA_W-1:0] load_c;
  logic [DATA_W-1:0] store_c;
  logic [LANES-1:0]  be_c;
  logic [ADDR_W-1:0] paddr_c;
  logic              take;

  lsl_lane_calc u_calc (
    .vaddr_lo (req_vaddr_lo),
    .cpu_big  (req_cpu_big),
    .dword    (req_dword),
    .geom     (geom)
  );

  lsl_load_merge u_load (
    .geom      (geom),
    .mem_data  (req_mem_data),
    .reg_data  (req_reg_data),
    .load_data (load_c)
  );

  lsl_store_shift u_store (
    .geom       (geom),
    .reg_data   (req_reg_data),
    .store_data (store_c),
    .byte_en    (be_c)
  );

  lsl_paddr_adj u_paddr (
    .paddr_lo   (req_paddr_lo),
    .rev_endian (req_rev_endian),
    .mem_big    (req_mem_big),
    .acc        (geom.acc),
    .paddr_out  (paddr_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_load_data  <= '0;
      rsp_store_data <= '0;
      rsp_byte_en    <= '0;
      rsp_offset     <= '0;
      rsp_paddr_lo   <= '0;
    end else if (take) begin
      rsp_load_data  <= load_c;
      rsp_store_data <= store_c;
      rsp_byte_en    <= be_c;
      rsp_offset     <= geom.offset;
      rsp_paddr_lo   <= paddr_c;
    end
  end
endmodule

// File: rtl/lsl_merge_chk.sv
module lsl_merge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_load_data,
  input logic [63:0] rsp_store_data,
  input logic [7:0]  rsp_byte_en,
  input logic [2:0]  rsp_offset
);
  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_load_data) &&
                                   $stable(rsp_store_data) && $stable(rsp_byte_en) &&
                                   $stable(rsp_offset)));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_byte_en) == int'(rsp_offset) + 1));

  // R9
  be_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_byte_en[0] || rsp_byte_en[4]));
endmodule

bind lsl_merge_top lsl_merge_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_load_data  (rsp_load_data),
  .rsp_store_data (rsp_store_data),
  .rsp_byte_en    (rsp_byte_en),
  .rsp_offset     (rsp_offset)
);

// File: tb/lsl_merge_top_tb.sv
module lsl_merge_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_vaddr_lo = '0;
  logic [2:0]  req_paddr_lo = '0;
  logic        req_cpu_big = 1'b0;
  logic        req_rev_endian = 1'b0;
  logic        req_mem_big = 1'b0;
  logic        req_dword = 1'b0;
  logic [63:0] req_mem_data = '0;
  logic [63:0] req_reg_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_load_data;
  logic [63:0] rsp_store_data;
  logic [7:0]  rsp_byte_en;
  logic [2:0]  rsp_offset;
  logic [2:0]  rsp_paddr_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lsl_merge_top u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int r_acc(input bit dw);
    return dw ? 7 : 3;
  endfunction
  function automatic int r_x(input int v, input bit be);
    return be ? (7 - v) : v;
  endfunction
  function automatic int r_off(input int v, input bit be, input bit dw);
    return r_x(v, be) % (r_acc(dw) + 1);
  endfunction
  function automatic int r_half(input int v, input bit be, input bit dw);
    return (!dw && r_x(v, be) >= 4) ? 1 : 0;
  endfunction
  function automatic logic [7:0] lane(input logic [63:0] d, input int n);
    return d[n*8 +: 8];
  endfunction

  function automatic logic [63:0] r_load(input int v, input bit be, input bit dw,
                                         input logic [63:0] m, input logic [63:0] r);
    logic [63:0] res = r;
    int a = r_acc(dw), o = r_off(v, be, dw), h = r_half(v, be, dw);
    for (int i = a - o; i <= a; i++)
      res[i*8 +: 8] = h ? lane(m, i + o + 1) : lane(m, i - (a - o));
    return res;
  endfunction

  function automatic logic [63:0] r_store(input int v, input bit be, input bit dw,
                                          input logic [63:0] r);
    logic [63:0] res = '0;
    int a = r_acc(dw), o = r_off(v, be, dw), h = r_half(v, be, dw);
    for (int i = 0; i < 8; i++) begin
      if (!h && i + a - o <= 7) res[i*8 +: 8] = lane(r, i + a - o);
      if (h && i - o - 1 >= 0)  res[i*8 +: 8] = lane(r, i - o - 1);
    end
    return res;
  endfunction

  function automatic logic [7:0] r_be(input int v, input bit be, input bit dw);
    logic [7:0] res = '0;
    int o = r_off(v, be, dw), h = r_half(v, be, dw);
    for (int i = 0; i <= o; i++) res[4*h + i] = 1'b1;
    return res;
  endfunction

  function automatic logic [2:0] r_paddr(input int p, input bit rev, input bit mb, input bit dw);
    int q = rev ? (7 - p) : p;
    if (!mb) q = dw ? 0 : (q / 4) * 4;
    return 3'(q);
  endfunction

  task automatic drive(input int v, input int p, input bit be, input bit rev,
                       input bit mb, input bit dw, input logic [63:0] m, input logic [63:0] r);
    req_vaddr_lo = 3'(v); req_paddr_lo = 3'(p); req_cpu_big = be;
    req_rev_endian = rev; req_mem_big = mb; req_dword = dw;
    req_mem_data = m; req_reg_data = r; req_valid = 1'b1;
  endtask

  task automatic verify(input int v, input int p, input bit be, input bit rev,
                        input bit mb, input bit dw, input logic [63:0] m, input logic [63:0] r);
    int h = r_half(v, be, dw);
    chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R3 offset", 64'(rsp_offset), 64'(r_off(v, be, dw)));
    if (h != 0) chk("R5 load H=1", rsp_load_data, r_load(v, be, dw, m, r));
    else        chk("R4 R6 load H=0", rsp_load_data, r_load(v, be, dw, m, r));
    if (h != 0) chk("R8 store H=1", rsp_store_data, r_store(v, be, dw, r));
    else        chk("R7 store H=0", rsp_store_data, r_store(v, be, dw, r));
    chk("R9 byte_en", 64'(rsp_byte_en), 64'(r_be(v, be, dw)));
    chk("R10 paddr", 64'(rsp_paddr_lo), 64'(r_paddr(p, rev, mb, dw)));
  endtask

  task automatic txn(input int v, input int p, input bit be, input bit rev,
                     input bit mb, input bit dw, input logic [63:0] m, input logic [63:0] r);
    @(negedge clk);
    drive(v, p, be, rev, mb, dw, m, r);
    @(negedge clk);
    req_valid = 1'b0;
    verify(v, p, be, rev, mb, dw, m, r);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // R3 R4 R5 R6 R7 R8 R9 R10: full sweep of offsets, byte orders, sizes
    for (int dw = 0; dw < 2; dw++)
      for (int be = 0; be < 2; be++)
        for (int v = 0; v < 8; v++)
          for (int mb = 0; mb < 2; mb++)
            txn(v, v ^ 5, be[0], v[0], mb[0], dw[0],
                64'h1122_3344_5566_7788, 64'hA1B2_C3D4_E5F6_0718);

    // R2: single request gives a one-cycle pulse
    @(negedge clk);
    chk("R2 pulse ends", 64'(rsp_valid), 64'd0);

    // R2: back-pressure holds response and blocks requests
    rsp_ready = 1'b0;
    txn(2, 1, 1'b0, 1'b0, 1'b1, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF);
    drive(5, 3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0);
    repeat (3) begin
      @(negedge clk);
      chk("R2 req_ready low while held", 64'(req_ready), 64'd0);
      chk("R2 held offset", 64'(rsp_offset), 64'd2);
      chk("R2 held load", rsp_load_data,
          r_load(2, 1'b0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF));
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 drained", 64'(rsp_valid), 64'd0);

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] m, r;
      int v, p;
      m = {$urandom, $urandom};
      r = {$urandom, $urandom};
      v = int'($urandom % 8);
      p = int'($urandom % 8);
      txn(v, p, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), m, r);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule